// File: doc/BRIEF.md
# Zero-Byte Signature Partner Finder

This block helps a last-level cache choose which two lines to store together as one XOR-merged physical line. For every incoming cache line it builds a content signature that records which of the upper six bytes of each 64-bit word are non-zero. The two least significant bytes of each word are left out of the signature. Two lines with the same signature have their non-zero bytes in the same places, so their XOR tends to leave many zero bytes and compresses well.

The signature is folded down to a set index into a small set-associative table of waiting lines. A lookup that finds an entry with exactly the same signature returns that entry's tag as the partner and takes the entry out of the table, so a waiting line is never handed out twice. A lookup that finds nothing leaves the requesting line behind as a future partner, replacing the oldest entry of a full set. Separate insert and remove commands let the surrounding cache add a line or withdraw one it no longer holds. Requests are pipelined: one may enter every cycle and each produces one response two cycles later.

Top module: `xor_partner_finder`

## Requirements
- R1: The signature has 6 bits per 64-bit word. Bit w*6+(b-2) is 1 exactly when byte b (bits b*8+7..b*8) of word w (line bits w*64+63..w*64) is non-zero, for b = 2..7; bytes 0 and 1 of every word have no effect on the signature, and an all-zero line gives an all-zero signature.
- R2: The set index is the XOR of the signature split into IDX_W-bit chunks, starting at bit 0; lines whose signatures fold to the same index compete for the same WAYS entries.
- R3: Each request accepted with req_valid high produces exactly one response with rsp_valid high two clock edges later, in request order, and a new request may be accepted every cycle; a request sees all table changes of the request before it.
- R4: A lookup hits only on an entry whose stored signature equals the request's signature in full; an entry in the same set with a different signature is not a partner.
- R5: A lookup that hits returns rsp_hit=1 with the stored entry's tag on rsp_tag and removes that entry, so a following lookup with the same signature does not return it again.
- R6: A lookup that misses returns rsp_hit=0 and rsp_tag=0 and stores the request's signature and tag, so a later lookup with that signature returns this tag.
- R7: When a line has to be stored into a set whose ways are all occupied, the entry stored longest ago is replaced.
- R8: A remove command (req_op=2) deletes the entry whose signature and tag both equal the request's and reports rsp_hit=1 with that tag; if no entry matches on both, nothing changes and rsp_hit=0.
- R9: An insert command (req_op=1) stores the line the same way a missing lookup does and always reports rsp_hit=0 with rsp_tag=0; a lookup is req_op=0.
- R10: After reset the table holds no entries and rsp_valid and rsp_hit are 0; rsp_hit is never 1 while rsp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 lookup, 1 insert, 2 remove, 3 no operation |
| req_line | input | WORDS*64 | Line data, word w at bits w*64+63..w*64 |
| req_tag | input | TAG_W | Tag identifying the requesting line |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_label | output | WORDS*6 | Signature of the request being answered |
| rsp_hit | output | 1 | A partner was found (lookup) or an entry was deleted (remove) |
| rsp_tag | output | TAG_W | Partner or deleted entry tag, 0 when rsp_hit is 0 |

## Verification
The hardest situation to reach from the ports is a set that is full of entries with different signatures, since only the fold relation ties distinct signatures to one set. The stimulus builds three lines whose single set bit lands in bit 0 of different index chunks, so all three fold to the same set with different signatures; filling both ways and adding the third shows both the exact-match rule and that the oldest entry is the one replaced, and a fourth lookup then shows which line survived. Back-to-back lookups with the same signature exercise the case where a response depends on a table write made by the request one cycle ahead.

// File: rtl/pf_pkg.sv
package pf_pkg;

  localparam int WORD_BYTES   = 8;
  localparam int SKIP_BYTES   = 2;
  localparam int SIG_PER_WORD = WORD_BYTES - SKIP_BYTES;

  typedef enum logic [1:0] {
    OP_LOOKUP = 2'd0,
    OP_INSERT = 2'd1,
    OP_REMOVE = 2'd2,
    OP_NONE   = 2'd3
  } pf_op_e;

endpackage

// File: rtl/pf_rst_sync.sv
module pf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/pf_label_gen.sv
module pf_label_gen
  import pf_pkg::*;
#(
  parameter int WORDS = 8
) (
  input  logic [WORDS*64-1:0]           line_i,
  output logic [WORDS*SIG_PER_WORD-1:0] label_o
);

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar b = SKIP_BYTES; b < WORD_BYTES; b++) begin : g_byte
      assign label_o[w*SIG_PER_WORD + (b - SKIP_BYTES)] = |line_i[w*64 + b*8 +: 8];
    end
  end

endmodule

// File: rtl/pf_index_fold.sv
module pf_index_fold #(
  parameter int IN_W  = 48,
  parameter int IDX_W = 4
) (
  input  logic [IN_W-1:0]  value_i,
  output logic [IDX_W-1:0] index_o
);

  localparam int CHUNKS = (IN_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W  = CHUNKS * IDX_W;

  logic [PAD_W-1:0] padded;

  assign padded = PAD_W'(value_i);

  always_comb begin
    index_o = '0;
    for (int k = 0; k < CHUNKS; k++) begin
      index_o = index_o ^ padded[k*IDX_W +: IDX_W];
    end
  end

endmodule

// File: rtl/pf_set_table.sv
module pf_set_table
  import pf_pkg::*;
#(
  parameter int LBL_W = 48,
  parameter int TAG_W = 16,
  parameter int IDX_W = 4,
  parameter int WAYS  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s1_valid_i,
  input  pf_op_e           s1_op_i,
  input  logic [IDX_W-1:0] s1_idx_i,
  input  logic [LBL_W-1:0] s1_label_i,
  input  logic [TAG_W-1:0] s1_tag_i,
  output logic             hit_o,
  output logic [TAG_W-1:0] hit_tag_o
);

  localparam int SETS   = 1 << IDX_W;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int RANK_W = WAY_W;
  localparam logic [RANK_W-1:0] OLDEST = RANK_W'(WAYS - 1);

  // Storage: valid and age rank are reset, payload is written with an enable
  logic [WAYS-1:0]   vld_q  [SETS];
  logic [RANK_W-1:0] rank_q [SETS][WAYS];
  logic [LBL_W-1:0]  lbl_q  [SETS][WAYS];
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];

  logic [WAYS-1:0]   set_v;
  logic [WAYS-1:0]   match_v;
  logic              found;
  logic [WAY_W-1:0]  fidx;
  logic [WAY_W-1:0]  vic;
  logic              set_full;
  logic              consume;
  logic              store;
  logic              wr_en;
  logic [WAYS-1:0]   nxt_v;
  logic [RANK_W-1:0] nxt_rank [WAYS];

  // Match: full signature compare, plus tag compare for remove
  always_comb begin
    set_v = vld_q[s1_idx_i];
    for (int w = 0; w < WAYS; w++) begin
      match_v[w] = set_v[w]
                 && (lbl_q[s1_idx_i][w] == s1_label_i)
                 && ((s1_op_i != OP_REMOVE) || (tag_q[s1_idx_i][w] == s1_tag_i));
    end
    found = 1'b0;
    fidx  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match_v[w]) begin
        found = 1'b1;
        fidx  = WAY_W'(w);
      end
    end
  end

  // Victim: lowest free way, else the way holding the oldest rank
  always_comb begin
    set_full = &set_v;
    vic      = '0;
    if (set_full) begin
      for (int w = 0; w < WAYS; w++) begin
        if (rank_q[s1_idx_i][w] == OLDEST) begin
          vic = WAY_W'(w);
        end
      end
    end else begin
      for (int w = WAYS - 1; w >= 0; w--) begin
        if (!set_v[w]) begin
          vic = WAY_W'(w);
        end
      end
    end
  end

  // Next state of the addressed set
  always_comb begin
    consume = s1_valid_i && found && ((s1_op_i == OP_LOOKUP) || (s1_op_i == OP_REMOVE));
    store   = s1_valid_i && (((s1_op_i == OP_LOOKUP) && !found) || (s1_op_i == OP_INSERT));
    wr_en   = consume || store;
    nxt_v   = set_v;
    for (int w = 0; w < WAYS; w++) begin
      nxt_rank[w] = rank_q[s1_idx_i][w];
    end
    if (consume) begin
      nxt_v[fidx] = 1'b0;
      for (int w = 0; w < WAYS; w++) begin
        if (set_v[w] && (rank_q[s1_idx_i][w] > rank_q[s1_idx_i][fidx])) begin
          nxt_rank[w] = rank_q[s1_idx_i][w] - 1'b1;
        end
      end
    end else if (store) begin
      for (int w = 0; w < WAYS; w++) begin
        if (set_v[w] && (WAY_W'(w) != vic)) begin
          nxt_rank[w] = rank_q[s1_idx_i][w] + 1'b1;
        end
      end
      nxt_v[vic]    = 1'b1;
      nxt_rank[vic] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          rank_q[s][w] <= '0;
        end
      end
    end else if (wr_en) begin
      vld_q[s1_idx_i] <= nxt_v;
      for (int w = 0; w < WAYS; w++) begin
        rank_q[s1_idx_i][w] <= nxt_rank[w];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (store) begin
      lbl_q[s1_idx_i][vic] <= s1_label_i;
      tag_q[s1_idx_i][vic] <= s1_tag_i;
    end
  end

  assign hit_o     = consume;
  assign hit_tag_o = tag_q[s1_idx_i][fidx];

endmodule

// File: rtl/xor_partner_finder.sv
module xor_partner_finder
  import pf_pkg::*;
#(
  parameter int WORDS = 8,
  parameter int TAG_W = 16,
  parameter int IDX_W = 4,
  parameter int WAYS  = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  input  logic [1:0]                     req_op,
  input  logic [WORDS*64-1:0]            req_line,
  input  logic [TAG_W-1:0]               req_tag,
  output logic                           rsp_valid,
  output logic [WORDS*SIG_PER_WORD-1:0]  rsp_label,
  output logic                           rsp_hit,
  output logic [TAG_W-1:0]               rsp_tag
);

  localparam int LBL_W = WORDS * SIG_PER_WORD;

  logic             rst_q_n;
  logic [LBL_W-1:0] label_c;
  logic [IDX_W-1:0] idx_c;

  // Stage 1 registers
  logic             s1_valid_q, s1_valid_d;
  pf_op_e           s1_op_q;
  logic [LBL_W-1:0] s1_label_q;
  logic [IDX_W-1:0] s1_idx_q;
  logic [TAG_W-1:0] s1_tag_q;

  // Stage 2 results
  logic             tbl_hit;
  logic [TAG_W-1:0] tbl_tag;
  logic             rsp_valid_d, rsp_hit_d;
  logic [TAG_W-1:0] rsp_tag_d;

  pf_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  pf_label_gen #(.WORDS(WORDS)) u_label (
    .line_i  (req_line),
    .label_o (label_c)
  );

  pf_index_fold #(.IN_W(LBL_W), .IDX_W(IDX_W)) u_fold (
    .value_i (label_c),
    .index_o (idx_c)
  );

  assign s1_valid_d = req_valid;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      s1_valid_q <= 1'b0;
    end else begin
      s1_valid_q <= s1_valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (req_valid) begin
      s1_op_q    <= pf_op_e'(req_op);
      s1_label_q <= label_c;
      s1_idx_q   <= idx_c;
      s1_tag_q   <= req_tag;
    end
  end

  pf_set_table #(
    .LBL_W (LBL_W),
    .TAG_W (TAG_W),
    .IDX_W (IDX_W),
    .WAYS  (WAYS)
  ) u_table (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .s1_valid_i (s1_valid_q),
    .s1_op_i    (s1_op_q),
    .s1_idx_i   (s1_idx_q),
    .s1_label_i (s1_label_q),
    .s1_tag_i   (s1_tag_q),
    .hit_o      (tbl_hit),
    .hit_tag_o  (tbl_tag)
  );

  always_comb begin
    rsp_valid_d = s1_valid_q;
    rsp_hit_d   = tbl_hit;
    rsp_tag_d   = tbl_hit ? tbl_tag : '0;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_hit   <= rsp_hit_d;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_valid_q) begin
      rsp_label <= s1_label_q;
      rsp_tag   <= rsp_tag_d;
    end
  end

endmodule

// File: rtl/pf_checker.sv
module pf_checker
  import pf_pkg::*;
#(
  parameter int WORDS = 8,
  parameter int TAG_W = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          req_valid,
  input logic [1:0]                    req_op,
  input logic [WORDS*64-1:0]           req_line,
  input logic [TAG_W-1:0]              req_tag,
  input logic                          rsp_valid,
  input logic [WORDS*SIG_PER_WORD-1:0] rsp_label,
  input logic                          rsp_hit,
  input logic [TAG_W-1:0]              rsp_tag
);

  logic [1:0] up_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_cnt <= 2'd0;
    end else if (up_cnt != 2'd3) begin
      up_cnt <= up_cnt + 2'd1;
    end
  end

  // R3
  resp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt >= 2'd2) |-> (rsp_valid == $past(req_valid, 2)));

  // R1
  zero_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((up_cnt >= 2'd2) && $past(req_valid && (req_line == '0), 2)) |-> (rsp_label == '0));

  // R9
  insert_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((up_cnt >= 2'd2) && $past(req_valid && (req_op == OP_INSERT), 2)) |-> !rsp_hit);

  // R8
  remove_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((up_cnt >= 2'd2) && $past(req_valid && (req_op == OP_REMOVE), 2) && rsp_hit)
      |-> (rsp_tag == $past(req_tag, 2)));

  // R10
  hit_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);

  // R6
  miss_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_tag == '0));

endmodule

bind xor_partner_finder pf_checker #(.WORDS(WORDS), .TAG_W(TAG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .req_valid (req_valid),
  .req_op    (req_op),
  .req_line  (req_line),
  .req_tag   (req_tag),
  .rsp_valid (rsp_valid),
  .rsp_label (rsp_label),
  .rsp_hit   (rsp_hit),
  .rsp_tag   (rsp_tag)
);

// File: tb/xor_partner_finder_tb.sv
module xor_partner_finder_tb;

  localparam int WORDS = 8;
  localparam int TAG_W = 16;
  localparam int LBL_W = WORDS * 6;
  localparam int LN_W  = WORDS * 64;

  logic             clk;
  logic             rst_n;
  logic             req_valid;
  logic [1:0]       req_op;
  logic [LN_W-1:0]  req_line;
  logic [TAG_W-1:0] req_tag;
  logic             rsp_valid;
  logic [LBL_W-1:0] rsp_label;
  logic             rsp_hit;
  logic [TAG_W-1:0] rsp_tag;

  int n_checks;
  int n_fail;
  int cyc;
  bit done;

  typedef struct {
    logic [LBL_W-1:0] lbl;
    logic             hit;
    logic [TAG_W-1:0] tag;
    int               issue;
    string            req;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;

  xor_partner_finder u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_line  (req_line),
    .req_tag   (req_tag),
    .rsp_valid (rsp_valid),
    .rsp_label (rsp_label),
    .rsp_hit   (rsp_hit),
    .rsp_tag   (rsp_tag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [LBL_W-1:0] sig_of(input logic [LN_W-1:0] ln);
    logic [LBL_W-1:0] s;
    s = '0;
    for (int w = 0; w < WORDS; w++) begin
      for (int b = 2; b < 8; b++) begin
        s[w*6 + b - 2] = (ln[w*64 + b*8 +: 8] != 8'h00);
      end
    end
    return s;
  endfunction

  function automatic logic [LN_W-1:0] put_byte(input logic [LN_W-1:0] ln, input int w,
                                               input int b, input logic [7:0] v);
    logic [LN_W-1:0] r;
    r = ln;
    r[w*64 + b*8 +: 8] = v;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [LBL_W-1:0] act, input logic [LBL_W-1:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Driver: one request per call, held for one cycle
  task automatic send(input logic [1:0] op, input logic [LN_W-1:0] ln, input logic [TAG_W-1:0] tg,
                      input logic exp_hit, input logic [TAG_W-1:0] exp_tag, input string req);
    exp_t e;
    req_valid = 1'b1;
    req_op    = op;
    req_line  = ln;
    req_tag   = tg;
    e.lbl   = sig_of(ln);
    e.hit   = exp_hit;
    e.tag   = exp_tag;
    e.issue = cyc;
    e.req   = req;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3", "unexpected response", 1, 0);
      end else begin
        cur = exp_q.pop_front();
        check((cyc - cur.issue) == 2, "R3", "latency", LBL_W'(cyc - cur.issue), 2);
        check(rsp_label == cur.lbl, cur.req, "label", rsp_label, cur.lbl);
        check(rsp_hit == cur.hit, cur.req, "hit", LBL_W'(rsp_hit), LBL_W'(cur.hit));
        check(rsp_tag == cur.tag, cur.req, "tag", LBL_W'(rsp_tag), LBL_W'(cur.tag));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [LN_W-1:0] ln_a, ln_a2, ln_b, ln_c, ln_d, ln_e, ln_r;
    n_checks = 0;
    n_fail   = 0;
    cyc      = 0;
    done     = 1'b0;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_op    = 2'd0;
    req_line  = '0;
    req_tag   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: quiet after reset
    check(!rsp_valid && !rsp_hit, "R10", "idle after reset", LBL_W'({rsp_valid, rsp_hit}), 0);

    // Three signatures that all fold to set 1 (R2): bits 0, 4, 8
    ln_a  = put_byte('0, 0, 2, 8'h11);
    ln_a2 = put_byte(put_byte(put_byte(put_byte('0, 0, 2, 8'h55), 0, 0, 8'hFF), 0, 1, 8'h01), 3, 0, 8'hCD);
    ln_b  = put_byte('0, 0, 6, 8'h22);
    ln_c  = put_byte('0, 1, 4, 8'h33);
    ln_d  = '1;
    ln_e  = put_byte('0, 7, 7, 8'h80);

    send(2'd0, ln_a,  16'h00A1, 1'b0, 16'h0000, "R6");   // miss, stored
    idle(2);
    send(2'd0, ln_a2, 16'h00A2, 1'b1, 16'h00A1, "R1");   // low bytes ignored, hit A1
    idle(2);
    send(2'd0, ln_a,  16'h00A3, 1'b0, 16'h0000, "R5");   // A1 consumed: miss, A3 stored
    idle(2);
    send(2'd0, ln_b,  16'h00B1, 1'b0, 16'h0000, "R4");   // same set, other signature
    idle(2);
    send(2'd0, ln_c,  16'h00C1, 1'b0, 16'h0000, "R2");   // set full: A3 replaced
    idle(2);
    send(2'd0, ln_a,  16'h00A4, 1'b0, 16'h0000, "R7");   // A3 gone; B1 now replaced
    idle(2);
    send(2'd0, ln_b,  16'h00B2, 1'b0, 16'h0000, "R7");   // B1 gone; C1 replaced by B2
    idle(2);
    send(2'd0, ln_a,  16'h00A5, 1'b1, 16'h00A4, "R7");   // A4 survived
    idle(2);

    send(2'd1, ln_d,  16'h00D1, 1'b0, 16'h0000, "R9");   // insert
    idle(2);
    send(2'd2, ln_d,  16'h00D9, 1'b0, 16'h0000, "R8");   // tag mismatch: kept
    idle(2);
    send(2'd2, ln_d,  16'h00D1, 1'b1, 16'h00D1, "R8");   // removed
    idle(2);
    send(2'd0, ln_d,  16'h00D2, 1'b0, 16'h0000, "R8");   // no longer present
    idle(2);

    // R3: back to back, second sees the first's write
    send(2'd0, ln_e,  16'h00E1, 1'b0, 16'h0000, "R3");
    send(2'd0, ln_e,  16'h00E2, 1'b1, 16'h00E1, "R3");
    send(2'd0, ln_e,  16'h00E3, 1'b0, 16'h0000, "R3");
    idle(2);

    // R1: zero line gives a zero signature
    send(2'd1, '0, 16'h0001, 1'b0, 16'h0000, "R1");
    idle(2);

    // R1, R9: random sparse lines through insert
    for (int i = 0; i < 20; i++) begin
      ln_r = '0;
      for (int k = 0; k < WORDS * 8; k++) begin
        if (($urandom % 3) != 0) ln_r[k*8 +: 8] = 8'($urandom);
      end
      send(2'd1, ln_r, TAG_W'(16'h1000 + i), 1'b0, 16'h0000, "R1");
    end
    idle(4);

    check(exp_q.size() == 0, "R3", "responses outstanding", LBL_W'(exp_q.size()), 0);
    finish_run();
  end

endmodule